// File: doc/BRIEF.md
# Subtract-free branch condition evaluator

This block decides whether a conditional branch is taken. It takes two register operands, a three-bit condition selector and a qualifying valid bit. It returns one taken flag.

Two conditions test the operands against each other, for equality or for inequality. The other four test the first operand against zero. No carry chain is used anywhere. Operand matching is done with a bitwise XOR followed by an OR reduction. The zero tests use only the sign bit and a flag that says whether any lower bit is set. Ordering between two registers is not provided.

The decision logic ends in an optional output register, selected by a parameter and enabled by default. With the register enabled, the flag is presented one clock after the inputs are sampled.

Top module: `brc_eval`

## Requirements
- R1: With cond_i = 3'b000 (equal), the branch is taken exactly when a_i and b_i match in every bit.
- R2: With cond_i = 3'b001 (not equal), the branch is taken exactly when a_i and b_i differ in at least one bit.
- R3: With cond_i = 3'b100 (below zero), the branch is taken exactly when bit 31 of a_i is 1.
- R4: With cond_i = 3'b101 (zero or above), the branch is taken exactly when bit 31 of a_i is 0.
- R5: With cond_i = 3'b010 (zero or below), the branch is taken when bit 31 of a_i is 1 or when all bits of a_i are 0.
- R6: With cond_i = 3'b011 (above zero), the branch is taken when bit 31 of a_i is 0 and at least one of bits 30..0 is 1.
- R7: For the four zero-compare codes (010, 011, 100, 101), the value of b_i has no effect on taken_o.
- R8: The reserved codes 3'b110 and 3'b111 always give taken_o = 0.
- R9: When valid_i is 0, taken_o is 0 whatever the other inputs are.
- R10: With the output register enabled, taken_o reflects the inputs sampled at the previous rising edge of clk. A synchronous active-high rst clears taken_o to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset; clears the output register |
| valid_i | input | 1 | Qualifies the evaluation |
| cond_i | input | 3 | Condition selector |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; used only by the equal and not-equal codes |
| taken_o | output | 1 | Branch-taken decision |

## Verification
The XOR match path and the sign/zero-detect path are both evaluated in the same cycle. Only the selector decides which of them reaches the output. The two paths agree or overlap when operands such as zero, one, all-ones, the largest positive value and the most negative value are crossed with one another under every code. For example, both operands at zero make equal, zero-or-below and zero-or-above true together, and the selector must still pick the right one. Each result one clock later is judged against a signed-arithmetic model, and the same sweep is repeated with valid low and with the reserved codes. Randomly drawn operand pairs, some forced equal and some not, then repeat the comparison. The zero-compare codes are also run twice with differing second operands to show that the second operand does not change the outcome.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int unsigned COND_W = 3;

    typedef enum logic [COND_W-1:0] {
        COND_EQ  = 3'b000,
        COND_NE  = 3'b001,
        COND_LEZ = 3'b010,
        COND_GTZ = 3'b011,
        COND_LTZ = 3'b100,
        COND_GEZ = 3'b101,
        COND_RS6 = 3'b110,
        COND_RS7 = 3'b111
    } brc_cond_e;

    // Flags produced by the two carry-free detectors.
    typedef struct packed {
        logic ops_differ; // some bit of a^b is set
        logic sign;       // top bit of a
        logic tail_nz;    // any bit below the top bit of a is set
    } brc_flags_t;

    function automatic logic is_zero_cmp(input brc_cond_e c);
        return (c == COND_LEZ) || (c == COND_GTZ) ||
               (c == COND_LTZ) || (c == COND_GEZ);
    endfunction

    function automatic logic is_reserved(input brc_cond_e c);
        return (c == COND_RS6) || (c == COND_RS7);
    endfunction

endpackage

// File: rtl/brc_match_detect.sv
module brc_match_detect #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned GROUP_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              differ_o
);
    localparam int unsigned N_GRP = (DATA_W + GROUP_W - 1) / GROUP_W;
    localparam int unsigned PAD_W = N_GRP * GROUP_W;

    logic [PAD_W-1:0] diff;
    logic [N_GRP-1:0] grp_any;

    // Bitwise XOR, zero-extended to a whole number of groups.
    always_comb begin
        diff = '0;
        diff[DATA_W-1:0] = a_i ^ b_i;
    end

    // Two-level OR tree: a per-group OR, then an OR across the groups.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_any[g] = |diff[g*GROUP_W +: GROUP_W];
    end

    assign differ_o = |grp_any;
endmodule

// File: rtl/brc_sign_class.sv
module brc_sign_class #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    output logic              sign_o,
    output logic              tail_nz_o
);
    localparam int unsigned MSB = DATA_W - 1;

    assign sign_o    = a_i[MSB];
    assign tail_nz_o = |a_i[MSB-1:0];
endmodule

// File: rtl/brc_select.sv
module brc_select
    import brc_pkg::*;
(
    input  logic       valid_i,
    input  brc_cond_e  cond_i,
    input  brc_flags_t flags_i,
    output logic       taken_o
);
    logic raw;

    always_comb begin
        unique case (cond_i)
            COND_EQ:  raw = !flags_i.ops_differ;
            COND_NE:  raw =  flags_i.ops_differ;
            COND_LEZ: raw =  flags_i.sign || !flags_i.tail_nz;
            COND_GTZ: raw = !flags_i.sign &&  flags_i.tail_nz;
            COND_LTZ: raw =  flags_i.sign;
            COND_GEZ: raw = !flags_i.sign;
            default:  raw = 1'b0;
        endcase
    end

    assign taken_o = valid_i && raw;
endmodule

// File: rtl/brc_eval.sv
module brc_eval
    import brc_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned GROUP_W = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [2:0]        cond_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              taken_o
);
    localparam int unsigned MSB = DATA_W - 1;

    brc_flags_t flags;
    brc_cond_e  cond;
    logic       taken_c;

    assign cond = brc_cond_e'(cond_i);

    brc_match_detect #(
        .DATA_W  (DATA_W),
        .GROUP_W (GROUP_W)
    ) u_match (
        .a_i      (a_i),
        .b_i      (b_i),
        .differ_o (flags.ops_differ)
    );

    brc_sign_class #(
        .DATA_W (DATA_W)
    ) u_sign (
        .a_i       (a_i),
        .sign_o    (flags.sign),
        .tail_nz_o (flags.tail_nz)
    );

    brc_select u_sel (
        .valid_i (valid_i),
        .cond_i  (cond),
        .flags_i (flags),
        .taken_o (taken_c)
    );

    if (REG_OUT) begin : g_reg
        logic taken_q;

        always_ff @(posedge clk) begin
            if (rst) taken_q <= 1'b0;
            else     taken_q <= taken_c;
        end

        assign taken_o = taken_q;

        // R9: a cycle without valid yields not-taken
        p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
            !valid_i |=> !taken_o);

        // R8: reserved selectors never take
        p_reserved_quiet_r8: assert property (@(posedge clk) disable iff (rst)
            (valid_i && is_reserved(cond)) |=> !taken_o);

        // R1: identical operands under the equal code take
        p_equal_take_r1: assert property (@(posedge clk) disable iff (rst)
            (valid_i && cond == COND_EQ && a_i == b_i) |=> taken_o);

        // R3: below-zero code follows the top bit of a
        p_below_sign_r3: assert property (@(posedge clk) disable iff (rst)
            (valid_i && cond == COND_LTZ) |=> (taken_o == $past(a_i[MSB])));

        // R6: a zero operand is never above zero
        p_zero_not_above_r6: assert property (@(posedge clk) disable iff (rst)
            (valid_i && cond == COND_GTZ && a_i == '0) |=> !taken_o);

        // R7: zero-compare codes do not depend on b
        p_zero_cmp_no_b_r7: assert property (@(posedge clk) disable iff (rst)
            (valid_i && is_zero_cmp(cond) && a_i == '0) |=>
                (taken_o == ($past(cond) == COND_LEZ || $past(cond) == COND_GEZ)));
    end else begin : g_comb
        assign taken_o = taken_c;
    end
endmodule

// File: tb/brc_eval_tb.sv
module brc_eval_tb;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_i = 1'b0;
    logic [2:0]   cond_i = 3'b000;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         taken_o;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    always #5 clk = ~clk;

    brc_eval u_dut (
        .clk     (clk),
        .rst     (rst),
        .valid_i (valid_i),
        .cond_i  (cond_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .taken_o (taken_o)
    );

    function automatic logic model(input logic v, input logic [2:0] c,
                                   input logic [W-1:0] a, input logic [W-1:0] b);
        if (!v) return 1'b0;
        case (c)
            3'b000: return a == b;
            3'b001: return a != b;
            3'b010: return $signed(a) <= 0;
            3'b011: return $signed(a) >  0;
            3'b100: return $signed(a) <  0;
            3'b101: return $signed(a) >= 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic v, input logic [2:0] c);
        if (!v) return "R9";
        case (c)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R5";
            3'b011: return "R6";
            3'b100: return "R3";
            3'b101: return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic judge(input string req, input logic exp);
        n_checks++;
        if (taken_o !== exp) begin
            n_fail++;
            $display("FAIL %s: cond=%0d a=%h b=%h taken=%b expected=%b",
                     req, cond_i, a_i, b_i, taken_o, exp);
        end
    endtask

    // Drive on the falling edge, sample just after the next rising edge (R10).
    task automatic run(input logic v, input logic [2:0] c,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic got);
        @(negedge clk);
        valid_i = v; cond_i = c; a_i = a; b_i = b;
        @(posedge clk); #1;
        got = taken_o;
        judge(req_of(v, c), model(v, c, a, b));
    endtask

    logic [W-1:0] corner [5];

    initial begin
        logic got, got2;
        corner[0] = 32'h0000_0000;
        corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF;
        corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h8000_0000;
        void'($urandom(32'd5171));

        // Reset state (R10)
        @(negedge clk); valid_i = 1'b1; cond_i = 3'b000;
        @(posedge clk); #1;
        judge("R10", 1'b0);
        @(negedge clk); rst = 1'b0;

        // Directed corner sweep: all codes, both valid levels
        for (int v = 0; v < 2; v++)
            for (int c = 0; c < 8; c++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        run(v[0], c[2:0], corner[i], corner[j], got);

        // R7: zero-compare codes with two different b values
        for (int c = 2; c < 6; c++)
            for (int i = 0; i < 5; i++) begin
                run(1'b1, c[2:0], corner[i], 32'h0, got);
                run(1'b1, c[2:0], corner[i], $urandom() | 32'h1, got2);
                n_checks++;
                if (got !== got2) begin
                    n_fail++;
                    $display("FAIL R7: cond=%0d a=%h taken=%b expected=%b",
                             c, corner[i], got2, got);
                end
            end

        // Random pairs, some equal, some different
        for (int k = 0; k < 3000; k++) begin
            logic [W-1:0] ra, rb;
            logic [2:0]   rc;
            logic         rv;
            ra = $urandom();
            case ($urandom_range(0, 3))
                0: rb = ra;
                1: rb = ra ^ (32'h1 << $urandom_range(0, 31));
                default: rb = $urandom();
            endcase
            if ($urandom_range(0, 3) == 0) ra = ra & 32'h0000_00FF;
            rc = 3'($urandom_range(0, 7));
            rv = ($urandom_range(0, 9) != 0);
            run(rv, rc, ra, rb, got);
        end

        // R10: synchronous reset overrides a taking input
        @(negedge clk);
        valid_i = 1'b1; cond_i = 3'b000; a_i = 32'h5; b_i = 32'h5; rst = 1'b1;
        @(posedge clk); #1;
        judge("R10", 1'b0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        judge("R10", 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, taken=%b expected=done", taken_o);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule